// File: doc/BRIEF.md
# Processor Presence Bitmap

This block holds one presence bit per processor slot and makes the whole set readable by firmware, one byte at a time, through a small I/O window. Each bit stands for one processor. Bit `b` of window byte `n` belongs to processor `8*n + b`. When the platform adds or removes a processor, it presents a plug or unplug event that carries the processor's number. The block then updates that bit. In the same cycle it pulses a strobe that the general-purpose event logic uses to latch its processor-hotplug status flag, and that flag causes the interrupt to be re-evaluated.

At reset the bitmap loads a vector that lists the processors already present at power-on. Firmware finds the changed processors by reading the window after the status flag is raised. Writes into the window are accepted and discarded. Reads wider than one byte, and reads outside the window, return zero.

Top module: `cpu_presence_map`

## Requirements
- R1: While `rst` is high the bitmap takes the value of `init_present`, and `io_rdata` and `gpe_cpu_set` are 0 on the cycle after each reset edge.
- R2: A byte read (`io_rd`=1, `io_size`=0) at address `BASE_ADDR + n`, for n from 0 to `N_CPUS/8 - 1` (0xAF00 to 0xAF1F by default), puts status byte `n` on `io_rdata` on the following cycle. Bit `b` of that byte is the presence bit of processor `8*n + b`.
- R3: A read at an address below `BASE_ADDR` or at `BASE_ADDR + N_CPUS/8` or above returns 0.
- R4: A plug event (`evt_valid`=1, `evt_plug`=1) with an in-range ID sets that processor's bit. Setting a bit that is already set leaves it set.
- R5: An unplug event (`evt_valid`=1, `evt_plug`=0) with an in-range ID clears that processor's bit. No other bit changes.
- R6: Every accepted event pulses `gpe_cpu_set` high for exactly the one cycle in which the updated bitmap first becomes readable. This holds for plug and for unplug, and also when the bit already had the requested value.
- R7: Only byte accesses are served. A read with `io_size` of 1 (16-bit) or 2 (32-bit) returns 0, even inside the window.
- R8: An event whose ID is `N_CPUS` (256) or higher changes no bit and does not pulse `gpe_cpu_set`.
- R9: A write strobe `io_wr` at any address, including inside the window, changes no bit of the bitmap.
- R10: A read issued in the same cycle as an event that touches the read byte returns the value from before that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the bitmap from `init_present` |
| init_present | input | N_CPUS | Processors present at power-on, one bit per processor ID |
| evt_valid | input | 1 | Hotplug event strobe |
| evt_plug | input | 1 | 1 = processor added, 0 = processor removed |
| evt_id | input | ID_W | Processor ID carried by the event |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe (has no effect) |
| io_addr | input | ADDR_W | I/O port address |
| io_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| io_rdata | output | 8 | Read data, valid the cycle after `io_rd` |
| gpe_cpu_set | output | 1 | One-cycle pulse that sets the processor-hotplug event status flag |

## Verification
The hardest case to reach from the ports is a read that lands in the same clock as an event on the byte being read. The reference model must then return the old byte, while the strobe and the new bit show up together one cycle later. The stimulus drives a read of byte 0 together with an unplug of processor 3, and a read of byte 31 together with a plug of processor 250. Both bytes are then read again on their own. Redundant events, IDs just past the limit, and window-edge addresses are also driven, each with the bench's bitmap model compared on every clock.

// File: rtl/cpu_presence_pkg.sv
package cpu_presence_pkg;

    // Access width encoding on io_size
    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_size_e;

    // Decoded event as seen by the storage
    typedef struct packed {
        logic accepted;
        logic plug;
    } evt_cmd_t;

    localparam int unsigned BITS_PER_BYTE = 8;

endpackage

// File: rtl/cpu_presence_decode.sv
module cpu_presence_decode
    import cpu_presence_pkg::*;
#(
    parameter int unsigned N_CPUS = 256,
    parameter int unsigned ID_W   = 9
) (
    input  logic              evt_valid,
    input  logic              evt_plug,
    input  logic [ID_W-1:0]   evt_id,
    output logic [N_CPUS-1:0] set_vec,
    output logic [N_CPUS-1:0] clr_vec,
    output evt_cmd_t          cmd
);
    localparam logic [ID_W:0] LIMIT = (ID_W+1)'(N_CPUS);

    always_comb begin
        cmd.accepted = evt_valid && ({1'b0, evt_id} < LIMIT);
        cmd.plug     = evt_plug;
    end

    for (genvar i = 0; i < N_CPUS; i++) begin : g_slot
        logic hit;
        assign hit        = cmd.accepted && (evt_id == ID_W'(i));
        assign set_vec[i] = hit &&  cmd.plug;
        assign clr_vec[i] = hit && !cmd.plug;
    end

endmodule

// File: rtl/cpu_presence_store.sv
module cpu_presence_store #(
    parameter int unsigned N_CPUS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CPUS-1:0] init_vec,
    input  logic [N_CPUS-1:0] set_vec,
    input  logic [N_CPUS-1:0] clr_vec,
    output logic [N_CPUS-1:0] bits
);
    for (genvar i = 0; i < N_CPUS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)             bits[i] <= init_vec[i];
            else if (set_vec[i]) bits[i] <= 1'b1;
            else if (clr_vec[i]) bits[i] <= 1'b0;
        end
    end

    // R5: set and clear never target the same slot
    a_r5_set_clr_exclusive: assert property (@(posedge clk) disable iff (rst)
        (set_vec & clr_vec) == '0);

endmodule

// File: rtl/cpu_presence_port.sv
module cpu_presence_port
    import cpu_presence_pkg::*;
#(
    parameter int unsigned N_CPUS    = 256,
    parameter int unsigned ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'hAF00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_rd,
    input  logic [1:0]        io_size,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [N_CPUS-1:0] bits,
    output logic [7:0]        io_rdata
);
    localparam int unsigned N_BYTES = N_CPUS / BITS_PER_BYTE;
    localparam int unsigned OFF_W   = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
    localparam logic [ADDR_W:0] LO  = (ADDR_W+1)'(BASE_ADDR);
    localparam logic [ADDR_W:0] HI  = LO + (ADDR_W+1)'(N_BYTES);

    logic [7:0]        byte_arr [N_BYTES];
    logic [ADDR_W:0]   addr_ext;
    logic [ADDR_W:0]   off_full;
    logic [OFF_W-1:0]  off;
    logic              in_win;
    logic              serve;

    for (genvar n = 0; n < N_BYTES; n++) begin : g_byte
        assign byte_arr[n] = bits[n*BITS_PER_BYTE +: BITS_PER_BYTE];
    end

    always_comb begin
        addr_ext = {1'b0, io_addr};
        in_win   = (addr_ext >= LO) && (addr_ext < HI);
        off_full = addr_ext - LO;
        off      = off_full[OFF_W-1:0];
        serve    = io_rd && in_win && (acc_size_e'(io_size) == ACC_BYTE);
    end

    always_ff @(posedge clk) begin
        if (rst)        io_rdata <= '0;
        else if (serve) io_rdata <= byte_arr[off];
        else            io_rdata <= '0;
    end

    // R3: reads outside the window return zero
    a_r3_outside_zero: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !in_win) |=> (io_rdata == 8'h00));

    // R7: wide accesses return zero
    a_r7_wide_zero: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_size != 2'd0) |=> (io_rdata == 8'h00));

    // R2 / R10: a byte read returns the byte as it stood at the read edge
    a_r2_byte_read: assert property (@(posedge clk) disable iff (rst)
        serve |=> (io_rdata == $past(byte_arr[off])));

endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map
    import cpu_presence_pkg::*;
#(
    parameter int unsigned N_CPUS    = 256,
    parameter int unsigned ID_W      = 9,
    parameter int unsigned ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'hAF00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CPUS-1:0] init_present,
    input  logic              evt_valid,
    input  logic              evt_plug,
    input  logic [ID_W-1:0]   evt_id,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_size,
    output logic [7:0]        io_rdata,
    output logic              gpe_cpu_set
);
    localparam int unsigned IDX_W = $clog2(N_CPUS);

    logic [N_CPUS-1:0] set_vec;
    logic [N_CPUS-1:0] clr_vec;
    logic [N_CPUS-1:0] bits;
    evt_cmd_t          cmd;

    cpu_presence_decode #(.N_CPUS(N_CPUS), .ID_W(ID_W)) u_decode (
        .evt_valid (evt_valid),
        .evt_plug  (evt_plug),
        .evt_id    (evt_id),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .cmd       (cmd)
    );

    cpu_presence_store #(.N_CPUS(N_CPUS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .init_vec (init_present),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .bits     (bits)
    );

    cpu_presence_port #(
        .N_CPUS(N_CPUS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) u_port (
        .clk      (clk),
        .rst      (rst),
        .io_rd    (io_rd),
        .io_size  (io_size),
        .io_addr  (io_addr),
        .bits     (bits),
        .io_rdata (io_rdata)
    );

    // Strobe leaves on the same edge that commits the bitmap update
    always_ff @(posedge clk) begin
        if (rst) gpe_cpu_set <= 1'b0;
        else     gpe_cpu_set <= cmd.accepted;
    end

    // R4: plug sets the addressed bit
    a_r4_plug_sets: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_plug && ({1'b0, evt_id} < (ID_W+1)'(N_CPUS)))
        |=> bits[$past(evt_id[IDX_W-1:0])]);

    // R5: unplug clears the addressed bit
    a_r5_unplug_clears: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_plug && ({1'b0, evt_id} < (ID_W+1)'(N_CPUS)))
        |=> !bits[$past(evt_id[IDX_W-1:0])]);

    // R6: strobe only follows an in-range event
    a_r6_strobe_cause: assert property (@(posedge clk) disable iff (rst)
        gpe_cpu_set |-> $past(evt_valid && ({1'b0, evt_id} < (ID_W+1)'(N_CPUS))));

    // R8: out-of-range IDs leave everything quiet
    a_r8_range_quiet: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && ({1'b0, evt_id} >= (ID_W+1)'(N_CPUS)))
        |=> ($stable(bits) && !gpe_cpu_set));

    // R9: writes alone never alter the bitmap
    a_r9_write_inert: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !evt_valid) |=> $stable(bits));

endmodule

// File: tb/cpu_presence_map_tb.sv
module cpu_presence_map_tb_top;

    localparam int N      = 256;
    localparam int ID_W   = 9;
    localparam int BASE   = 'hAF00;
    localparam int NBYTES = N / 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [N-1:0]   init_present;
    logic           evt_valid, evt_plug;
    logic [ID_W-1:0] evt_id;
    logic           io_rd, io_wr;
    logic [15:0]    io_addr;
    logic [1:0]     io_size;
    logic [7:0]     io_rdata;
    logic           gpe_cpu_set;

    always #10 clk = ~clk;  // 50 MHz

    cpu_presence_map dut_i (
        .clk(clk), .rst(rst), .init_present(init_present),
        .evt_valid(evt_valid), .evt_plug(evt_plug), .evt_id(evt_id),
        .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_size(io_size),
        .io_rdata(io_rdata), .gpe_cpu_set(gpe_cpu_set)
    );

    // ---------------- reference model ----------------
    bit [N-1:0] mdl;
    logic [7:0] exp_rdata = 8'h00;
    logic       exp_gpe   = 1'b0;
    bit         live      = 1'b0;
    int         vectors   = 0;
    int         fails     = 0;
    string      cur_req   = "R1";

    always @(posedge clk) begin
        int a;
        a = int'(io_addr);
        // read result taken from the pre-update model (R10)
        if (rst) exp_rdata = 8'h00;
        else if (io_rd && io_size == 2'd0 && a >= BASE && a < BASE + NBYTES)
            exp_rdata = mdl[(a-BASE)*8 +: 8];
        else exp_rdata = 8'h00;
        exp_gpe = !rst && evt_valid && (int'(evt_id) < N);
        if (rst) mdl = init_present;
        else if (evt_valid && int'(evt_id) < N) mdl[int'(evt_id)] = evt_plug;
        live = 1'b1;
    end

    always @(posedge clk) begin
        #5;
        if (live) begin
            vectors += 2;
            if (io_rdata !== exp_rdata) begin
                fails++;
                $display("FAIL %s io_rdata actual=%02h expected=%02h at %0t",
                         cur_req, io_rdata, exp_rdata, $time);
            end
            if (gpe_cpu_set !== exp_gpe) begin
                fails++;
                $display("FAIL %s gpe_cpu_set actual=%0b expected=%0b at %0t",
                         cur_req, gpe_cpu_set, exp_gpe, $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input bit rd, input bit wr, input int addr, input int sz,
                       input bit ev, input bit plug, input int id);
        @(negedge clk);
        io_rd = rd; io_wr = wr; io_addr = 16'(addr); io_size = 2'(sz);
        evt_valid = ev; evt_plug = plug; evt_id = ID_W'(id);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rd_byte(input int n);
        cyc(1, 0, BASE + n, 0, 0, 0, 0);
    endtask

    task automatic event_only(input bit plug, input int id);
        cyc(0, 0, 0, 0, 1, plug, id);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired in %s", cur_req);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++)
            init_present[i] = (i % 3 == 0) || (i == 100) || (i == 255);
        rst = 1'b1;
        io_rd = 0; io_wr = 0; io_addr = 0; io_size = 0;
        evt_valid = 0; evt_plug = 0; evt_id = 0;
        repeat (3) @(negedge clk);
        // R1: event during reset must not survive
        cyc(0, 0, 0, 0, 1, 1, 1);
        rst = 1'b0;
        idle(1);

        // R1, R2: read back the whole window after reset
        cur_req = "R2";
        for (int n = 0; n < NBYTES; n++) rd_byte(n);
        idle(1);

        // R3: addresses just outside the window
        cur_req = "R3";
        cyc(1, 0, BASE - 1, 0, 0, 0, 0);
        cyc(1, 0, BASE + NBYTES, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);

        // R7: wide accesses inside the window
        cur_req = "R7";
        cyc(1, 0, BASE, 1, 0, 0, 0);
        cyc(1, 0, BASE, 2, 0, 0, 0);
        cyc(1, 0, BASE + 4, 3, 0, 0, 0);

        // R4, R6: plugs, including one on a bit already set
        cur_req = "R4";
        event_only(1, 5);   rd_byte(0);
        event_only(1, 200); rd_byte(25);
        event_only(1, 0);   rd_byte(0);
        event_only(1, 254); event_only(1, 253); rd_byte(31);

        // R5, R6: unplugs, including one on a bit already clear
        cur_req = "R5";
        event_only(0, 6);   rd_byte(0);
        event_only(0, 100); rd_byte(12);
        event_only(0, 1);   rd_byte(0);
        event_only(0, 255); rd_byte(31);

        // R8: IDs at and above the limit
        cur_req = "R8";
        event_only(1, 256); event_only(0, 256); event_only(1, 511);
        event_only(0, 300); rd_byte(0); rd_byte(31);

        // R9: writes inside and outside the window
        cur_req = "R9";
        for (int n = 0; n < NBYTES; n += 7) cyc(0, 1, BASE + n, 0, 0, 0, 0);
        cyc(0, 1, BASE + NBYTES, 0, 0, 0, 0);
        for (int n = 0; n < NBYTES; n += 7) rd_byte(n);

        // R10: read collides with an event on the same byte
        cur_req = "R10";
        cyc(1, 0, BASE + 0, 0, 1, 0, 3);
        rd_byte(0);
        cyc(1, 0, BASE + 31, 0, 1, 1, 250);
        rd_byte(31);

        // R6: back-to-back events give back-to-back strobes
        cur_req = "R6";
        event_only(1, 40); event_only(0, 40); event_only(1, 41);
        rd_byte(5);

        // R1: reset mid-run restores the power-on vector
        cur_req = "R1";
        @(negedge clk); rst = 1'b1;
        idle(2);
        @(negedge clk); rst = 1'b0;
        for (int n = 0; n < NBYTES; n += 5) rd_byte(n);
        idle(3);

        summary();
        $finish;
    end

endmodule